// File: doc/BRIEF.md
# Pointer Lower-Bound Check Unit

This execution-stage unit carries out the lower-bound half of a pointer bounds check. It keeps a small file of bound registers, each holding a lower limit. For each checked instruction it takes the bound register number from the decoder, the address operand (a register value or an effective address that was computed upstream), the current operating mode, the lock and address-size prefix flags, and the default-size bit of the code segment. One cycle later it reports one of three results: the check passed, a bound-range fault occurred, or an invalid-opcode fault occurred.

The address is compared without a sign against the selected lower bound. An address strictly below the bound raises a bound-range fault and loads the fault code 1 into the status register. Before the comparison, mode-dependent legality rules are applied. If any rule is violated, the unit reports an invalid-opcode fault. In that case the comparison is suppressed and the status is left as it was. A separate write port loads the lower-bound registers. The unit performs no memory access and has no connection to the arithmetic flags.

Top module: `lbchk_unit`

## Requirements
- R1: After reset, `out_valid`, `out_br` and `out_ud` are 0, `out_status` is 0, and all lower bounds are 0.
- R2: Each cycle with `in_valid` high produces `out_valid` high on the next cycle. A cycle with `in_valid` low produces `out_valid`, `out_br` and `out_ud` low on the next cycle.
- R3: On a legal check whose address is strictly below the selected lower bound, `out_br` is 1 and `out_status` becomes 1. An address equal to or above the bound passes with `out_br` 0.
- R4: When a check passes, `out_status` keeps its previous value and both fault outputs are 0.
- R5: The mode code on `in_mode` is 0 for real, 1 for virtual-8086, 2 for protected, 3 for compatibility and 4 for 64-bit. In mode 4 all 64 bits of the address and the bound are compared. In all other modes only bits 31:0 are compared, and the comparison is unsigned.
- R6: A check with `in_lock` set reports `out_ud` in every mode.
- R7: `in_idx[2:0]` is the register field and `in_idx[3]` is the REX extension bit. A register number of 4 or more reports `out_ud`. In mode 4 the number is the full 4 bits, so values 4 to 15 fault. In other modes `in_idx[3]` is ignored.
- R8: In modes 0 to 3, `out_ud` is reported when `in_asize` equals `in_cs_d`. Either combination means 16-bit addressing.
- R9: In mode 4, `in_asize` and `in_cs_d` never cause `out_ud`.
- R10: When `out_ud` is reported, `out_br` is 0 and `out_status` is unchanged, even if the address is below the bound.
- R11: `bnd_we` writes `bnd_wlb` into bound `bnd_widx`. A check in the same cycle uses the value the bound held before that write.
- R12: Mode codes 5 to 7 are reserved and report `out_ud`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bnd_we | input | 1 | Lower-bound write enable |
| bnd_widx | input | 2 | Bound register to write |
| bnd_wlb | input | 64 | Lower bound value to write |
| in_valid | input | 1 | Check request strobe |
| in_idx | input | 4 | Bound register number (REX bit in bit 3) |
| in_addr | input | 64 | Address operand |
| in_mode | input | 3 | Operating mode code |
| in_lock | input | 1 | Lock prefix present |
| in_asize | input | 1 | Address-size prefix present |
| in_cs_d | input | 1 | Code segment default-size bit |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_br | output | 1 | Bound-range fault |
| out_ud | output | 1 | Invalid-opcode fault |
| out_status | output | 8 | Bound status register |

## Verification
The hardest case to reach from the ports is an invalid-opcode fault on a check whose address is also below the bound, while the status register still reads 0. Only in that state does a wrong write of the status register show up. The status register cannot be cleared except by reset, and any earlier bound fault sets it for good. The stimulus therefore applies a fresh reset, reloads the bounds, and only then issues the faulting requests with low addresses. The 32-bit truncation cases use bounds whose upper halves are nonzero, so that a check which passes in a 32-bit mode fails in 64-bit mode.

// File: rtl/lbchk_pkg.sv
package lbchk_pkg;
  localparam logic [2:0] MODE_REAL   = 3'd0;
  localparam logic [2:0] MODE_V86    = 3'd1;
  localparam logic [2:0] MODE_PROT   = 3'd2;
  localparam logic [2:0] MODE_COMPAT = 3'd3;
  localparam logic [2:0] MODE_LONG   = 3'd4;
  localparam int unsigned FAIL_CODE  = 1;
endpackage

// File: rtl/lbchk_bound_file.sv
module lbchk_bound_file #(
  parameter int unsigned NUM_BND = 4,
  parameter int unsigned ADDR_W  = 64,
  localparam int unsigned SEL_W  = $clog2(NUM_BND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  widx,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [SEL_W-1:0]  ridx,
  output logic [ADDR_W-1:0] rdata
);
  logic [ADDR_W-1:0] lb_q [NUM_BND];

  for (genvar g = 0; g < NUM_BND; g++) begin : g_bnd
    logic hit;
    assign hit = we && (widx == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lb_q[g] <= '0;
      else if (hit) lb_q[g] <= wdata;
    end
  end

  assign rdata = lb_q[ridx];
endmodule

// File: rtl/lbchk_legal.sv
module lbchk_legal
  import lbchk_pkg::*;
#(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned LEG_W   = 3,
  parameter int unsigned NUM_BND = 4
) (
  input  logic [2:0]       mode,
  input  logic [IDX_W-1:0] idx,
  input  logic             lock,
  input  logic             asize,
  input  logic             cs_d,
  output logic             is_long,
  output logic             ud
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_BND);
  logic [IDX_W-1:0] idx_eff;
  logic             reserved, addr16, bad_idx;

  always_comb begin
    is_long  = (mode == MODE_LONG);
    reserved = (mode > MODE_LONG);
    idx_eff  = is_long ? idx : {{(IDX_W-LEG_W){1'b0}}, idx[LEG_W-1:0]};
    bad_idx  = (idx_eff >= LIMIT);
    addr16   = !is_long && (asize == cs_d);
    ud       = lock || reserved || bad_idx || addr16;
  end
endmodule

// File: rtl/lbchk_compare.sv
module lbchk_compare #(
  parameter int unsigned ADDR_W = 64,
  localparam int unsigned NW    = ADDR_W / 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lb,
  input  logic              wide,
  output logic              below
);
  logic below_full, below_narrow;
  always_comb begin
    below_full   = addr < lb;
    below_narrow = addr[NW-1:0] < lb[NW-1:0];
    below        = wide ? below_full : below_narrow;
  end
endmodule

// File: rtl/lbchk_unit.sv
module lbchk_unit
  import lbchk_pkg::*;
#(
  parameter int unsigned NUM_BND = 4,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned STAT_W  = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_BND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_we,
  input  logic [SEL_W-1:0]  bnd_widx,
  input  logic [ADDR_W-1:0] bnd_wlb,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [2:0]        in_mode,
  input  logic              in_lock,
  input  logic              in_asize,
  input  logic              in_cs_d,
  output logic              out_valid,
  output logic              out_br,
  output logic              out_ud,
  output logic [STAT_W-1:0] out_status
);
  localparam logic [STAT_W-1:0] FAIL_VAL = STAT_W'(FAIL_CODE);

  logic [ADDR_W-1:0] lb_sel;
  logic              is_long, ud_c, below;
  logic              valid_d, br_d, ud_d, stat_en;
  logic [STAT_W-1:0] status_d;
  logic              valid_q, br_q, ud_q;
  logic [STAT_W-1:0] status_q;

  lbchk_bound_file #(.NUM_BND(NUM_BND), .ADDR_W(ADDR_W)) u_bounds (
    .clk(clk), .rst_n(rst_n), .we(bnd_we), .widx(bnd_widx), .wdata(bnd_wlb),
    .ridx(in_idx[SEL_W-1:0]), .rdata(lb_sel)
  );

  lbchk_legal #(.IDX_W(IDX_W), .LEG_W(3), .NUM_BND(NUM_BND)) u_legal (
    .mode(in_mode), .idx(in_idx), .lock(in_lock), .asize(in_asize),
    .cs_d(in_cs_d), .is_long(is_long), .ud(ud_c)
  );

  lbchk_compare #(.ADDR_W(ADDR_W)) u_cmp (
    .addr(in_addr), .lb(lb_sel), .wide(is_long), .below(below)
  );

  // next state
  always_comb begin
    valid_d  = in_valid;
    ud_d     = in_valid && ud_c;
    br_d     = in_valid && !ud_c && below;
    stat_en  = br_d;
    status_d = FAIL_VAL;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      br_q    <= 1'b0;
      ud_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      br_q    <= br_d;
      ud_q    <= ud_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else if (stat_en) status_q <= status_d;
  end

  assign out_valid  = valid_q;
  assign out_br     = br_q;
  assign out_ud     = ud_q;
  assign out_status = status_q;

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_br && !out_ud));
  assert_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_br |-> (out_status == FAIL_VAL));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_br |-> $stable(out_status));
  assert_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_lock) |=> out_ud);
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_br && out_ud));
endmodule

// File: tb/test_lbchk_unit.sv
module test_lbchk_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bnd_we;
  logic [1:0]  bnd_widx;
  logic [63:0] bnd_wlb;
  logic        in_valid;
  logic [3:0]  in_idx;
  logic [63:0] in_addr;
  logic [2:0]  in_mode;
  logic        in_lock, in_asize, in_cs_d;
  logic        out_valid, out_br, out_ud;
  logic [7:0]  out_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbchk_unit i_lbchk_unit (
    .clk(clk), .rst_n(rst_n), .bnd_we(bnd_we), .bnd_widx(bnd_widx),
    .bnd_wlb(bnd_wlb), .in_valid(in_valid), .in_idx(in_idx),
    .in_addr(in_addr), .in_mode(in_mode), .in_lock(in_lock),
    .in_asize(in_asize), .in_cs_d(in_cs_d), .out_valid(out_valid),
    .out_br(out_br), .out_ud(out_ud), .out_status(out_status)
  );

  task automatic check(string req, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,br,ud,status} actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; bnd_we = 0; bnd_widx = 0; bnd_wlb = 0;
    in_valid = 0; in_idx = 0; in_addr = 0; in_mode = 3'd2;
    in_lock = 0; in_asize = 0; in_cs_d = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_bound(logic [1:0] idx, logic [63:0] val);
    @(negedge clk);
    bnd_we = 1; bnd_widx = idx; bnd_wlb = val;
    @(negedge clk);
    bnd_we = 0;
  endtask

  task automatic load_bounds();
    write_bound(2'd0, 64'h0000_0000_0000_1000);
    write_bound(2'd1, 64'hFFFF_FFFF_0000_0000);
    write_bound(2'd2, 64'h0000_0000_8000_0000);
    write_bound(2'd3, 64'h0000_0001_0000_0010);
  endtask

  task automatic run(string req, logic [3:0] idx, logic [63:0] addr,
                     logic [2:0] mode, logic lock, logic asize, logic csd,
                     logic ebr, logic eud, logic [7:0] est);
    @(negedge clk);
    in_valid = 1; in_idx = idx; in_addr = addr; in_mode = mode;
    in_lock = lock; in_asize = asize; in_cs_d = csd;
    @(negedge clk);
    in_valid = 0;
    check(req, {out_valid, out_br, out_ud, out_status}, {1'b1, ebr, eud, est});
  endtask

  task automatic test_reset();
    apply_reset();
    check("R1", {out_valid, out_br, out_ud, out_status}, 11'h0);
    // R1: bounds cleared, so address 0 passes against bound 0
    run("R1", 4'd0, 64'h0, 3'd4, 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic test_compare();
    load_bounds();
    run("R3", 4'd0, 64'h1000, 3'd2, 0, 0, 1, 0, 0, 8'h00);
    run("R3", 4'd0, 64'h0FFF, 3'd2, 0, 0, 1, 1, 0, 8'h01);
    run("R4", 4'd0, 64'h2000, 3'd2, 0, 0, 1, 0, 0, 8'h01);
  endtask

  task automatic test_width();
    run("R5", 4'd1, 64'h0,               3'd2, 0, 0, 1, 0, 0, 8'h01);
    run("R5", 4'd1, 64'h10,              3'd4, 0, 0, 0, 1, 0, 8'h01);
    run("R5", 4'd3, 64'h20,              3'd3, 0, 0, 1, 0, 0, 8'h01);
    run("R5", 4'd3, 64'h8,               3'd3, 0, 0, 1, 1, 0, 8'h01);
    run("R5", 4'd3, 64'h20,              3'd4, 0, 0, 0, 1, 0, 8'h01);
    run("R5", 4'd2, 64'h7FFF_FFFF,       3'd2, 0, 0, 1, 1, 0, 8'h01);
    run("R5", 4'd2, 64'hFFFF_FFFF,       3'd2, 0, 0, 1, 0, 0, 8'h01);
  endtask

  task automatic test_priority();
    apply_reset();
    load_bounds();
    run("R10", 4'd0, 64'h0, 3'd2, 1, 0, 1, 0, 1, 8'h00);
    run("R10", 4'd5, 64'h0, 3'd2, 0, 0, 1, 0, 1, 8'h00);
    for (int m = 0; m < 5; m++)
      run("R6", 4'd0, 64'h5000, 3'(m), 1, 1, 0, 0, 1, 8'h00);
  endtask

  task automatic test_index();
    for (int i = 4; i < 8; i++)
      run("R7", 4'(i), 64'h5000, 3'd2, 0, 0, 1, 0, 1, 8'h00);
    run("R7", 4'd8,  64'h5000, 3'd4, 0, 0, 0, 0, 1, 8'h00);
    run("R7", 4'd12, 64'h5000, 3'd4, 0, 0, 0, 0, 1, 8'h00);
    run("R7", 4'd8,  64'h0FFF, 3'd2, 0, 0, 1, 1, 0, 8'h01);
  endtask

  task automatic test_addr_size();
    for (int m = 0; m < 4; m++) begin
      run("R8", 4'd0, 64'h5000, 3'(m), 0, 0, 0, 0, 1, 8'h01);
      run("R8", 4'd0, 64'h5000, 3'(m), 0, 1, 1, 0, 1, 8'h01);
      run("R8", 4'd0, 64'h5000, 3'(m), 0, 1, 0, 0, 0, 8'h01);
      run("R8", 4'd0, 64'h5000, 3'(m), 0, 0, 1, 0, 0, 8'h01);
    end
    run("R9", 4'd0, 64'h5000, 3'd4, 0, 0, 0, 0, 0, 8'h01);
    run("R9", 4'd0, 64'h5000, 3'd4, 0, 1, 1, 0, 0, 8'h01);
    for (int m = 5; m < 8; m++)
      run("R12", 4'd0, 64'h5000, 3'(m), 0, 0, 1, 0, 1, 8'h01);
  endtask

  task automatic test_write_port();
    write_bound(2'd0, 64'h10);
    @(negedge clk);
    bnd_we = 1; bnd_widx = 2'd0; bnd_wlb = 64'h100;
    in_valid = 1; in_idx = 4'd0; in_addr = 64'h50; in_mode = 3'd4;
    in_lock = 0; in_asize = 0; in_cs_d = 0;
    @(negedge clk);
    bnd_we = 0; in_valid = 0;
    check("R11", {out_valid, out_br, out_ud, out_status}, {3'b100, 8'h01});
    run("R11", 4'd0, 64'h50, 3'd4, 0, 0, 0, 1, 0, 8'h01);
    @(negedge clk);
    check("R2", {out_valid, out_br, out_ud}, 11'h0);
  endtask

  initial begin
    test_reset();
    test_compare();
    test_width();
    test_priority();
    test_index();
    test_addr_size();
    test_write_port();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule